// File: doc/BRIEF.md
# Bus Monitor Response Timer and Gap Checker

This block sits on the monitor side of a dual-redundant command/response serial bus. Upstream word logic delivers single-cycle strobes. One strobe marks the mid-parity point that ends each word. The other marks the mid-sync point that starts each word. A two-bit tag says what kind of word just ended. A one-microsecond tick paces every measurement. From these inputs the block times the silence between a command and the answer to it. It pulses a no-response flag when the answer does not arrive in time. When the answer does arrive, it reports the elapsed time.

A transfer between two terminals gets a longer window. That window opens at the end of the receive command and closes at the start of the first data word. The second command and the status word from the transmitting terminal fall inside it. The window length comes from one of four codes in a small configuration register.

The block can also check for short bus silence. When that check is on, a response or a new message that starts too soon after the previous word raises a one-cycle format-error pulse. Message storage uses this pulse for its block status.

Top module: `bmt_resp_monitor`

## Requirements
- R1: The configuration register is written through `cfg_we`/`cfg_wdata`. Bits [1:0] hold the timeout code and bit 2 enables the gap check. Both fields reset to 0, so after reset the block uses code 0 with the gap check off.
- R2: For a normal command, codes 0, 1, 2 and 3 give no-response limits of 18, 23, 82 and 140 ticks, counted from the command's mid-parity strobe.
- R3: For a terminal-to-terminal transfer, codes 0, 1, 2 and 3 give limits of 61, 66, 122 and 180 ticks, counted from the receive command's mid-parity strobe.
- R4: A mid-parity strobe with tag 2'b01 (command) opens a normal window, and tags 2'b00 (data) and 2'b11 (status) open nothing. The first mid-sync strobe whose `sync_is_data` is 0 closes the window. One cycle later the block pulses `resp_done` for one cycle and shows the number of ticks counted in `resp_us`, including a tick in the closing cycle.
- R5: In a normal window, a data-word sync (`sync_is_data`=1) pauses the window while the controller's data word is on the bus. The next mid-parity strobe restarts the count from zero.
- R6: A mid-parity strobe with tag 2'b10 opens a terminal-to-terminal window. Further mid-parity strobes and non-data syncs do not close or restart it, and the first data-word sync closes it as in R4.
- R7: When a tick brings the count up to the limit, `no_resp` pulses for one cycle in the next cycle and the block returns to idle. If a closing sync comes in the same cycle as that tick, the sync wins: `resp_done` pulses and `no_resp` stays low.
- R8: With the gap check enabled, a checked sync that comes fewer than 4 ticks after the most recent mid-parity strobe raises a one-cycle `fmt_err` pulse one cycle after the sync. A sync at 4 ticks or more raises nothing.
- R9: Three kinds of sync are checked: a non-data sync while idle (new message), the sync that closes a normal window (response), and the second non-data sync of a terminal-to-terminal window (status reply). Data-word syncs, the embedded second command, and any sync before the first mid-parity strobe after reset are never checked.
- R10: With the gap check disabled, `fmt_err` stays low however short the gap.
- R11: `busy` is high exactly while a window is open, including while it is paused.
- R12: After reset, `busy`, `no_resp`, `fmt_err` and `resp_done` are low and `resp_us` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration value: [1:0] timeout code, [2] gap-check enable |
| par_evt | input | 1 | Mid-parity strobe: a word has just ended |
| par_kind | input | 2 | Kind of the ended word: 00 data, 01 command, 10 receive command of a terminal-to-terminal transfer, 11 status |
| sync_evt | input | 1 | Mid-sync strobe: a word is starting |
| sync_is_data | input | 1 | The starting word has a data sync |
| busy | output | 1 | A response window is open |
| no_resp | output | 1 | One-cycle no-response timeout pulse |
| fmt_err | output | 1 | One-cycle short-gap format-error pulse |
| resp_done | output | 1 | One-cycle pulse when a window closes on a sync |
| resp_us | output | CNT_W (8) | Elapsed ticks of the last closed window |

## Verification
The assertions assume that a mid-parity strobe and a mid-sync strobe never arrive in the same cycle. They also assume the tick is at most one cycle wide, and that `par_kind` and `sync_is_data` are only read while their strobes are high. The bench drives every strobe through its own task, which raises the strobe for exactly one cycle and then clears it. Strobes are always driven in separate cycles. The one deliberate overlap, a tick together with a closing sync, is allowed by these assumptions and is used to test the R7 tie rule.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

    // Kind of the word whose mid-parity point was just seen.
    typedef enum logic [1:0] {
        WK_DATA    = 2'b00,
        WK_CMD     = 2'b01,
        WK_CMD_R2R = 2'b10,
        WK_STAT    = 2'b11
    } word_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_RESP   = 2'b01,
        ST_INWORD = 2'b10,
        ST_R2R    = 2'b11
    } mon_state_e;

    typedef struct packed {
        logic       gap_en;
        logic [1:0] sel;
    } mon_cfg_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bmt_cfg_reg.sv
module bmt_cfg_reg
    import bmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [2:0] wdata,
    output mon_cfg_t   cfg
);

    mon_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.sel    = wdata[1:0];
            cfg_d.gap_en = wdata[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/bmt_limit_sel.sv
module bmt_limit_sel #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned TMO_N0 = 18,
    parameter int unsigned TMO_N1 = 23,
    parameter int unsigned TMO_N2 = 82,
    parameter int unsigned TMO_N3 = 140,
    parameter int unsigned TMO_R0 = 61,
    parameter int unsigned TMO_R1 = 66,
    parameter int unsigned TMO_R2 = 122,
    parameter int unsigned TMO_R3 = 180
) (
    input  logic [1:0]       sel,
    input  logic             r2r,
    output logic [CNT_W-1:0] limit
);

    logic [CNT_W-1:0] norm_lim, r2r_lim;

    always_comb begin
        unique case (sel)
            2'd0: begin norm_lim = CNT_W'(TMO_N0); r2r_lim = CNT_W'(TMO_R0); end
            2'd1: begin norm_lim = CNT_W'(TMO_N1); r2r_lim = CNT_W'(TMO_R1); end
            2'd2: begin norm_lim = CNT_W'(TMO_N2); r2r_lim = CNT_W'(TMO_R2); end
            default: begin norm_lim = CNT_W'(TMO_N3); r2r_lim = CNT_W'(TMO_R3); end
        endcase
        limit = r2r ? r2r_lim : norm_lim;
    end

endmodule

// File: rtl/bmt_gap_timer.sv
module bmt_gap_timer #(
    parameter int unsigned GAP_MIN = 4,
    localparam int unsigned GAP_W  = $clog2(GAP_MIN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic restart,
    output logic short_gap
);

    typedef struct packed {
        logic             valid;
        logic [GAP_W-1:0] cnt;
    } gap_regs_t;

    gap_regs_t g_d, g_q;
    logic [GAP_W:0] seen;

    always_comb begin
        g_d = g_q;
        if (restart) begin
            g_d.valid = 1'b1;
            g_d.cnt   = '0;
        end else if (us_tick && (g_q.cnt < GAP_W'(GAP_MIN))) begin
            g_d.cnt = g_q.cnt + GAP_W'(1);
        end
        // Ticks since the last mid-parity, counting one arriving this cycle.
        seen      = {1'b0, g_q.cnt} + {{GAP_W{1'b0}}, us_tick};
        short_gap = g_q.valid && (seen < {1'b0, GAP_W'(GAP_MIN)});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

endmodule

// File: rtl/bmt_resp_monitor.sv
module bmt_resp_monitor
    import bmt_pkg::*;
#(
    parameter int unsigned TMO_N0  = 18,
    parameter int unsigned TMO_N1  = 23,
    parameter int unsigned TMO_N2  = 82,
    parameter int unsigned TMO_N3  = 140,
    parameter int unsigned TMO_R0  = 61,
    parameter int unsigned TMO_R1  = 66,
    parameter int unsigned TMO_R2  = 122,
    parameter int unsigned TMO_R3  = 180,
    parameter int unsigned GAP_MIN = 4,
    localparam int unsigned TMO_MAX = umax(umax(umax(TMO_N0, TMO_N1), umax(TMO_N2, TMO_N3)),
                                           umax(umax(TMO_R0, TMO_R1), umax(TMO_R2, TMO_R3))),
    localparam int unsigned CNT_W   = $clog2(TMO_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_wdata,
    input  logic             par_evt,
    input  logic [1:0]       par_kind,
    input  logic             sync_evt,
    input  logic             sync_is_data,
    output logic             busy,
    output logic             no_resp,
    output logic             fmt_err,
    output logic             resp_done,
    output logic [CNT_W-1:0] resp_us
);

    typedef struct packed {
        mon_state_e       state;
        logic [1:0]       phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] resp_us;
        logic             no_resp;
        logic             fmt_err;
        logic             done;
    } mon_regs_t;

    mon_cfg_t         cfg_q;
    logic [CNT_W-1:0] limit;
    logic             short_gap;
    mon_regs_t        s_d, s_q;
    logic [CNT_W-1:0] cnt_tick, elapsed;
    logic             chk_sync, closing;
    word_kind_e       kind;

    bmt_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    bmt_limit_sel #(
        .CNT_W  (CNT_W),
        .TMO_N0 (TMO_N0), .TMO_N1 (TMO_N1), .TMO_N2 (TMO_N2), .TMO_N3 (TMO_N3),
        .TMO_R0 (TMO_R0), .TMO_R1 (TMO_R1), .TMO_R2 (TMO_R2), .TMO_R3 (TMO_R3)
    ) u_lim (
        .sel   (cfg_q.sel),
        .r2r   (s_q.state == ST_R2R),
        .limit (limit)
    );

    bmt_gap_timer #(
        .GAP_MIN (GAP_MIN)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .restart   (par_evt),
        .short_gap (short_gap)
    );

    always_comb begin
        s_d         = s_q;
        s_d.no_resp = 1'b0;
        s_d.fmt_err = 1'b0;
        s_d.done    = 1'b0;
        kind        = word_kind_e'(par_kind);
        cnt_tick    = s_q.cnt + CNT_W'(1);
        elapsed     = us_tick ? cnt_tick : s_q.cnt;
        chk_sync    = 1'b0;
        closing     = 1'b0;

        unique case (s_q.state)
            ST_IDLE: begin
                // A command sync while idle starts a new message.
                if (sync_evt && !sync_is_data) chk_sync = 1'b1;
            end
            ST_RESP: begin
                if (sync_evt && sync_is_data) begin
                    s_d.state = ST_INWORD;
                end else if (sync_evt) begin
                    chk_sync = 1'b1;
                    closing  = 1'b1;
                end else if (us_tick) begin
                    if (cnt_tick >= limit) begin
                        s_d.no_resp = 1'b1;
                        s_d.state   = ST_IDLE;
                    end else begin
                        s_d.cnt = cnt_tick;
                    end
                end
            end
            ST_INWORD: begin
                // Controller data word on the bus: the count is paused.
            end
            ST_R2R: begin
                if (sync_evt && sync_is_data) begin
                    closing = 1'b1;
                end else begin
                    if (sync_evt) begin
                        if (s_q.phase == 2'd1) chk_sync = 1'b1;
                        if (s_q.phase != 2'd2) s_d.phase = s_q.phase + 2'd1;
                    end
                    if (us_tick) begin
                        if (cnt_tick >= limit) begin
                            s_d.no_resp = 1'b1;
                            s_d.state   = ST_IDLE;
                        end else begin
                            s_d.cnt = cnt_tick;
                        end
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase

        if (closing) begin
            s_d.done    = 1'b1;
            s_d.resp_us = elapsed;
            s_d.state   = ST_IDLE;
        end

        // Mid-parity strobes open or restart windows; an open
        // terminal-to-terminal window is not disturbed by them.
        if (par_evt && (s_q.state != ST_R2R)) begin
            if (kind == WK_CMD) begin
                s_d.state = ST_RESP;
                s_d.cnt   = '0;
            end else if (kind == WK_CMD_R2R) begin
                s_d.state = ST_R2R;
                s_d.cnt   = '0;
                s_d.phase = 2'd0;
            end else if (s_q.state == ST_INWORD) begin
                s_d.state = ST_RESP;
                s_d.cnt   = '0;
            end
        end

        s_d.fmt_err = chk_sync && cfg_q.gap_en && short_gap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.state != ST_IDLE);
    assign no_resp   = s_q.no_resp;
    assign fmt_err   = s_q.fmt_err;
    assign resp_done = s_q.done;
    assign resp_us   = s_q.resp_us;

endmodule

// File: rtl/bmt_resp_monitor_chk.sv
module bmt_resp_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       us_tick,
    input logic       par_evt,
    input logic [1:0] par_kind,
    input logic       sync_evt,
    input logic       busy,
    input logic       no_resp,
    input logic       fmt_err,
    input logic       resp_done,
    input logic       gap_en
);

    p_timeout_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        no_resp |=> !no_resp);

    p_timeout_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        no_resp |-> $past(us_tick));

    p_timeout_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        no_resp |-> !busy);

    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(no_resp && resp_done));

    p_done_after_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> $past(sync_evt));

    p_cmd_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (par_evt && par_kind == 2'b01) |=> busy);

    p_r2r_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (par_evt && par_kind == 2'b10) |=> busy);

    p_fmt_after_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> $past(sync_evt));

    p_fmt_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> $past(gap_en));

    p_busy_falls_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (no_resp || resp_done));

endmodule

bind bmt_resp_monitor bmt_resp_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick   (us_tick),
    .par_evt   (par_evt),
    .par_kind  (par_kind),
    .sync_evt  (sync_evt),
    .busy      (busy),
    .no_resp   (no_resp),
    .fmt_err   (fmt_err),
    .resp_done (resp_done),
    .gap_en    (cfg_q.gap_en)
);

// File: tb/bmt_resp_monitor_test.sv
module bmt_resp_monitor_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic       par_evt = 1'b0;
    logic [1:0] par_kind = '0;
    logic       sync_evt = 1'b0;
    logic       sync_is_data = 1'b0;
    logic       busy, no_resp, fmt_err, resp_done;
    logic [7:0] resp_us;

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 1'b0;
    int  norm_lim [4] = '{18, 23, 82, 140};
    int  r2r_lim  [4] = '{61, 66, 122, 180};

    bmt_resp_monitor uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .us_tick      (us_tick),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .par_evt      (par_evt),
        .par_kind     (par_kind),
        .sync_evt     (sync_evt),
        .sync_is_data (sync_is_data),
        .busy         (busy),
        .no_resp      (no_resp),
        .fmt_err      (fmt_err),
        .resp_done    (resp_done),
        .resp_us      (resp_us)
    );

    always #2 clk = ~clk;

    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
        end
    endtask

    task automatic par(input logic [1:0] k);
        par_evt = 1'b1; par_kind = k;
        @(negedge clk);
        par_evt = 1'b0; par_kind = 2'b00;
    endtask

    task automatic sync(input bit d);
        sync_evt = 1'b1; sync_is_data = d;
        @(negedge clk);
        sync_evt = 1'b0; sync_is_data = 1'b0;
    endtask

    task automatic cfg(input int sel, input bit gap);
        cfg_we = 1'b1; cfg_wdata = {gap, 2'(sel)};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        expect_eq("R12", "busy", busy, 0);
        expect_eq("R12", "no_resp", no_resp, 0);
        expect_eq("R12", "fmt_err", fmt_err, 0);
        expect_eq("R12", "resp_done", resp_done, 0);
        expect_eq("R12", "resp_us", resp_us, 0);
    endtask

    task automatic t_defaults();
        // R1/R10: reset config means gap check off and code 0
        par(2'b01); ticks(1); sync(1'b0);
        expect_eq("R10", "fmt_err short gap disabled", fmt_err, 0);
        expect_eq("R1", "resp_done", resp_done, 1);
        expect_eq("R1", "resp_us", resp_us, 1);
        par(2'b01); ticks(17);
        expect_eq("R1", "no_resp before 18", no_resp, 0);
        ticks(1);
        expect_eq("R1", "no_resp at 18", no_resp, 1);
        @(negedge clk);
    endtask

    task automatic t_timeout(input int sel, input bit r2r);
        string req;
        int    lim;
        req = r2r ? "R3" : "R2";
        lim = r2r ? r2r_lim[sel] : norm_lim[sel];
        cfg(sel, 1'b0);
        par(r2r ? 2'b10 : 2'b01);
        ticks(lim - 1);
        expect_eq(req, "busy before limit", busy, 1);
        expect_eq(req, "no_resp before limit", no_resp, 0);
        ticks(1);
        expect_eq(req, "no_resp at limit", no_resp, 1);
        expect_eq("R7", "busy after timeout", busy, 0);
        @(negedge clk);
        expect_eq("R7", "no_resp one cycle", no_resp, 0);
    endtask

    task automatic t_response();
        cfg(2, 1'b0);
        par(2'b01); ticks(10);
        expect_eq("R11", "busy open", busy, 1);
        sync(1'b0);
        expect_eq("R4", "resp_done", resp_done, 1);
        expect_eq("R4", "resp_us", resp_us, 10);
        expect_eq("R11", "busy closed", busy, 0);
        @(negedge clk);
        expect_eq("R4", "resp_done one cycle", resp_done, 0);
        par(2'b00);
        expect_eq("R4", "data parity opens nothing", busy, 0);
        par(2'b11);
        expect_eq("R4", "status parity opens nothing", busy, 0);
    endtask

    task automatic t_tie();
        cfg(0, 1'b0);
        par(2'b01); ticks(17);
        us_tick = 1'b1; sync_evt = 1'b1; sync_is_data = 1'b0;
        @(negedge clk);
        us_tick = 1'b0; sync_evt = 1'b0;
        expect_eq("R7", "tie resp_done", resp_done, 1);
        expect_eq("R7", "tie no_resp", no_resp, 0);
        expect_eq("R7", "tie resp_us", resp_us, 18);
    endtask

    task automatic t_rx_data();
        cfg(0, 1'b0);
        par(2'b01); ticks(2); sync(1'b1);
        expect_eq("R5", "busy in data word", busy, 1);
        ticks(30);
        expect_eq("R5", "no timeout while paused", no_resp, 0);
        expect_eq("R5", "still busy", busy, 1);
        par(2'b00); ticks(17);
        expect_eq("R5", "no timeout after restart", no_resp, 0);
        sync(1'b0);
        expect_eq("R5", "resp_done", resp_done, 1);
        expect_eq("R5", "resp_us from data parity", resp_us, 17);
    endtask

    task automatic t_r2r_close();
        cfg(0, 1'b0);
        par(2'b10); ticks(2);
        sync(1'b0); par(2'b01); ticks(20);
        sync(1'b0);
        expect_eq("R6", "status does not close", resp_done, 0);
        expect_eq("R6", "busy", busy, 1);
        par(2'b11); ticks(5);
        sync(1'b1);
        expect_eq("R6", "resp_done on data sync", resp_done, 1);
        expect_eq("R6", "resp_us", resp_us, 27);
        expect_eq("R6", "busy closed", busy, 0);
    endtask

    task automatic t_gap_response();
        cfg(3, 1'b1);
        par(2'b01); ticks(3); sync(1'b0);
        expect_eq("R8", "fmt_err at 3", fmt_err, 1);
        @(negedge clk);
        expect_eq("R8", "fmt_err one cycle", fmt_err, 0);
        par(2'b01); ticks(4); sync(1'b0);
        expect_eq("R8", "fmt_err at 4", fmt_err, 0);
        expect_eq("R8", "resp_done at 4", resp_done, 1);
    endtask

    task automatic t_gap_intermsg();
        cfg(0, 1'b1);
        par(2'b11); ticks(3); sync(1'b0);
        expect_eq("R9", "idle command short", fmt_err, 1);
        par(2'b01); ticks(5); sync(1'b0);
        expect_eq("R9", "response 5 ok", fmt_err, 0);
        par(2'b11); ticks(4); sync(1'b0);
        expect_eq("R9", "idle command at 4", fmt_err, 0);
        par(2'b01); ticks(1); sync(1'b1);
        expect_eq("R9", "contiguous data sync exempt", fmt_err, 0);
        par(2'b00); ticks(5); sync(1'b0);
        expect_eq("R9", "response after data", resp_done, 1);
        par(2'b11); ticks(1); sync(1'b1);
        expect_eq("R9", "idle data sync exempt", fmt_err, 0);
    endtask

    task automatic t_gap_r2r();
        cfg(0, 1'b1);
        par(2'b10); sync(1'b0);
        expect_eq("R9", "second command exempt", fmt_err, 0);
        par(2'b01); ticks(2); sync(1'b0);
        expect_eq("R9", "status reply short", fmt_err, 1);
        par(2'b11); ticks(2); sync(1'b1);
        expect_eq("R9", "data sync exempt", fmt_err, 0);
        expect_eq("R6", "r2r resp_done", resp_done, 1);
        expect_eq("R6", "r2r resp_us", resp_us, 4);
    endtask

    task automatic t_gap_off();
        cfg(0, 1'b0);
        par(2'b01); sync(1'b0);
        expect_eq("R10", "fmt_err disabled", fmt_err, 0);
        expect_eq("R10", "resp_us zero", resp_us, 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_defaults();
        for (int s = 0; s < 4; s++) t_timeout(s, 1'b0);
        for (int s = 0; s < 4; s++) t_timeout(s, 1'b1);
        t_response();
        t_tie();
        t_rx_data();
        t_r2r_close();
        t_gap_response();
        t_gap_intermsg();
        t_gap_r2r();
        t_gap_off();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule